// File: doc/BRIEF.md
# Cipher Bit-Field Manipulation Unit

This execution unit sits in the datapath of a cipher-oriented processor and handles the bit-level data movement that block ciphers need between their arithmetic steps. It supports three kinds of operation on word-wide operands:

- **Extract** cuts a variable-length field out of a register.
- **Concatenate** joins the valid low parts of two registers into one word.
- **Rotate** turns a word left or right, with wrap-around.

Splitting a block into small pieces for substitution, rebuilding a larger block from those pieces, and the rotations of round functions all map directly onto these three operations.

Each request arrives with a valid strobe. A request carries:

- a 2-bit operation code;
- two source operands;
- the control fields for the operation: start position, field length and the two valid-bit counts.

The rotate amount is the second operand. Exactly one clock later, the unit presents one registered result with its own valid flag. The word width is a parameter, 32 by default. Every control field is one bit wider than the bit-index width, so values above the word width can be expressed. The unit gives those values defined meanings.

Top module: `fieldops_unit`

## Requirements
- R1: Extract (opCode 00) returns result bit j = srcA bit (startPos + j) for every j below the effective field length where startPos + j < WIDTH. Bit 0 is the least significant bit of every operand and of the result.
- R2: In an extract, every result bit at or above the effective field length is 0. Source positions at or beyond WIDTH read as 0. A field length of 0 gives an all-zero result.
- R3: An extract field length larger than WIDTH acts as WIDTH.
- R4: Concatenate (opCode 01) puts the low cntB bits of srcB at result bits 0 to cntB-1 and the low cntA bits of srcA directly above them. All result bits at or above cntA + cntB are 0.
- R5: When cntA + cntB exceeds WIDTH, concatenate keeps only the lowest WIDTH bits of the joined value.
- R6: Concatenate valid counts greater than WIDTH act as WIDTH.
- R7: Rotate left (opCode 10) moves srcA toward the most significant end by (srcB mod WIDTH). Bits leaving the top re-enter at bit 0. An amount of 0 or WIDTH returns srcA unchanged.
- R8: Rotate right (opCode 11) moves srcA toward bit 0 by (srcB mod WIDTH). Bits leaving bit 0 re-enter at the top.
- R9: The operation code alone selects the function: 00 extract, 01 concatenate, 10 rotate left, 11 rotate right.
- R10: outValid is high in exactly the cycle after a cycle with inValid high. A cycle without inValid leaves result unchanged. A synchronous active-high reset clears outValid and result to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Request strobe; all other inputs are taken in this cycle |
| opCode | input | 2 | Operation select (00 extract, 01 concat, 10 rotl, 11 rotr) |
| srcA | input | WIDTH | First operand: extract source, upper concat part, rotate data |
| srcB | input | WIDTH | Second operand: lower concat part, rotate amount |
| startPos | input | $clog2(WIDTH)+1 | Extract start bit position |
| fieldLen | input | $clog2(WIDTH)+1 | Extract field length |
| cntA | input | $clog2(WIDTH)+1 | Valid low-bit count of srcA for concat |
| cntB | input | $clog2(WIDTH)+1 | Valid low-bit count of srcB for concat |
| result | output | WIDTH | Registered result |
| outValid | output | 1 | Result valid, one cycle after an accepted request |

## Verification
The only state is the result register and its valid flag. A wrong decode or mask therefore shows up at the ports on the very next clock edge after the offending request, as a wrong bit pattern. A stuck or leaking valid flag shows up one cycle after any idle cycle, and a result register that loads without a request shows up the same way. The sweeps cover every start position, length and count, including values beyond the word width, so an error at the clamp or truncation boundaries appears as soon as the first value past the boundary is tried.

// File: rtl/fieldops_pkg.sv
package fieldops_pkg;

  typedef enum logic [1:0] {
    OP_EXTRACT = 2'b00,
    OP_CONCAT  = 2'b01,
    OP_ROTL    = 2'b10,
    OP_ROTR    = 2'b11
  } fieldop_e;

  // strobes from control to datapath; at most one function strobe is set
  typedef struct packed {
    logic load;
    logic selExtract;
    logic selConcat;
    logic selRotL;
    logic selRotR;
  } fieldStrobe_t;

endpackage

// File: rtl/fieldops_ctrl.sv
module fieldops_ctrl
  import fieldops_pkg::*;
(
  input  logic         inValid,
  input  logic [1:0]   opCode,
  output fieldStrobe_t strobes
);

  fieldop_e opSel;
  assign opSel = fieldop_e'(opCode);

  always_comb begin
    strobes            = '0;
    strobes.load       = inValid;
    if (inValid) begin
      unique case (opSel)
        OP_EXTRACT: strobes.selExtract = 1'b1;
        OP_CONCAT:  strobes.selConcat  = 1'b1;
        OP_ROTL:    strobes.selRotL    = 1'b1;
        OP_ROTR:    strobes.selRotR    = 1'b1;
        default:    strobes            = '0;
      endcase
    end
  end

endmodule

// File: rtl/fieldops_dp.sv
module fieldops_dp
  import fieldops_pkg::*;
#(
  parameter int W  = 32,
  parameter int LW = $clog2(W) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  fieldStrobe_t  strobes,
  input  logic [W-1:0]  srcA,
  input  logic [W-1:0]  srcB,
  input  logic [LW-1:0] startPos,
  input  logic [LW-1:0] fieldLen,
  input  logic [LW-1:0] cntA,
  input  logic [LW-1:0] cntB,
  output logic [W-1:0]  result,
  output logic          outValid
);

  localparam int AW = (W > 1) ? $clog2(W) : 1;
  localparam logic [LW-1:0] W_LW = LW'(W);
  localparam logic [W-1:0]  W_WW = W'(W);

  function automatic logic [LW-1:0] clampCount(input logic [LW-1:0] c);
    return (c > W_LW) ? W_LW : c;
  endfunction

  function automatic logic [W-1:0] lowMask(input logic [LW-1:0] k);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (i < int'(k));
    return m;
  endfunction

  // extract
  logic [LW-1:0] lenEff;
  logic [W-1:0]  exShifted, exRes;
  assign lenEff    = clampCount(fieldLen);
  assign exShifted = srcA >> startPos;
  assign exRes     = exShifted & lowMask(lenEff);

  // concatenate
  logic [LW-1:0] nA, nB;
  logic [W-1:0]  partA, partB, catRes;
  assign nA     = clampCount(cntA);
  assign nB     = clampCount(cntB);
  assign partA  = srcA & lowMask(nA);
  assign partB  = srcB & lowMask(nB);
  assign catRes = partB | (partA << nB);

  // rotate
  logic [AW-1:0]  rotAmt;
  logic [2*W-1:0] dblL, dblR;
  logic [W-1:0]   rotLRes, rotRRes;
  assign rotAmt  = AW'(srcB % W_WW);
  assign dblL    = {srcA, srcA} << rotAmt;
  assign dblR    = {srcA, srcA} >> rotAmt;
  assign rotLRes = dblL[2*W-1:W];
  assign rotRRes = dblR[W-1:0];

  logic [W-1:0] nextRes;
  always_comb begin
    nextRes = '0;
    if (strobes.selExtract) nextRes = exRes;
    if (strobes.selConcat)  nextRes = catRes;
    if (strobes.selRotL)    nextRes = rotLRes;
    if (strobes.selRotR)    nextRes = rotRRes;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      result   <= '0;
    end else begin
      outValid <= strobes.load;
      if (strobes.load) result <= nextRes;
    end
  end

endmodule

// File: rtl/fieldops_unit.sv
module fieldops_unit
  import fieldops_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   inValid,
  input  logic [1:0]             opCode,
  input  logic [WIDTH-1:0]       srcA,
  input  logic [WIDTH-1:0]       srcB,
  input  logic [$clog2(WIDTH):0] startPos,
  input  logic [$clog2(WIDTH):0] fieldLen,
  input  logic [$clog2(WIDTH):0] cntA,
  input  logic [$clog2(WIDTH):0] cntB,
  output logic [WIDTH-1:0]       result,
  output logic                   outValid
);

  localparam int LW = $clog2(WIDTH) + 1;

  fieldStrobe_t ctrlStrobes;

  fieldops_ctrl ctrl_i (
    .inValid (inValid),
    .opCode  (opCode),
    .strobes (ctrlStrobes)
  );

  fieldops_dp #(.W(WIDTH), .LW(LW)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobes  (ctrlStrobes),
    .srcA     (srcA),
    .srcB     (srcB),
    .startPos (startPos),
    .fieldLen (fieldLen),
    .cntA     (cntA),
    .cntB     (cntB),
    .result   (result),
    .outValid (outValid)
  );

endmodule

// File: rtl/fieldops_chk.sv
module fieldops_chk
  import fieldops_pkg::*;
#(
  parameter int W  = 32,
  parameter int LW = $clog2(W) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          inValid,
  input logic [1:0]    opCode,
  input logic [W-1:0]  srcA,
  input logic [W-1:0]  srcB,
  input logic [LW-1:0] fieldLen,
  input logic [LW-1:0] cntA,
  input logic [LW-1:0] cntB,
  input fieldStrobe_t  strobes,
  input logic [W-1:0]  result,
  input logic          outValid
);

  localparam logic [W-1:0] W_WW = W'(W);

  p_valid_follows_r10: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  p_idle_no_valid_r10: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  p_idle_holds_result_r10: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(result));

  p_one_function_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.selExtract, strobes.selConcat, strobes.selRotL, strobes.selRotR}));

  p_empty_field_r2: assert property (@(posedge clk) disable iff (rst)
    (inValid && opCode == 2'b00 && fieldLen == '0) |=> (result == '0));

  p_empty_concat_r4: assert property (@(posedge clk) disable iff (rst)
    (inValid && opCode == 2'b01 && cntA == '0 && cntB == '0) |=> (result == '0));

  p_rotate_identity_r7: assert property (@(posedge clk) disable iff (rst)
    (inValid && opCode[1] && (srcB % W_WW) == '0) |=> (result == $past(srcA)));

endmodule

bind fieldops_unit fieldops_chk #(.W(WIDTH), .LW(LW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .opCode   (opCode),
  .srcA     (srcA),
  .srcB     (srcB),
  .fieldLen (fieldLen),
  .cntA     (cntA),
  .cntB     (cntB),
  .strobes  (ctrlStrobes),
  .result   (result),
  .outValid (outValid)
);

// File: tb/fieldops_unit_tb_top.sv
module fieldops_unit_tb_top;

  localparam int W  = 8;
  localparam int LW = $clog2(W) + 1;

  logic          clk = 1'b0;
  logic          rst;
  logic          inValid;
  logic [1:0]    opCode;
  logic [W-1:0]  srcA, srcB;
  logic [LW-1:0] startPos, fieldLen, cntA, cntB;
  logic [W-1:0]  result;
  logic          outValid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  fieldops_unit #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .opCode(opCode),
    .srcA(srcA), .srcB(srcB), .startPos(startPos), .fieldLen(fieldLen),
    .cntA(cntA), .cntB(cntB), .result(result), .outValid(outValid)
  );

  function automatic logic [W-1:0] pattern(input int i);
    case (i % 5)
      0: return 8'hA5;
      1: return 8'h3C;
      2: return 8'hFF;
      3: return 8'h81;
      default: return 8'h6E;
    endcase
  endfunction

  function automatic logic [W-1:0] refExtract(input logic [W-1:0] a, input int s, input int k);
    logic [W-1:0] r = '0;
    int kk = (k > W) ? W : k;
    for (int j = 0; j < W; j++)
      if (j < kk && s + j < W) r[j] = a[s + j];
    return r;
  endfunction

  function automatic logic [W-1:0] refConcat(input logic [W-1:0] a, input logic [W-1:0] b,
                                             input int n1, input int n2);
    logic [W-1:0] r = '0;
    int c1 = (n1 > W) ? W : n1;
    int c2 = (n2 > W) ? W : n2;
    for (int j = 0; j < W; j++) begin
      if (j < c2) r[j] = b[j];
      else if (j - c2 < c1) r[j] = a[j - c2];
    end
    return r;
  endfunction

  function automatic logic [W-1:0] refRot(input logic [W-1:0] a, input int amt, input bit left);
    logic [W-1:0] r = '0;
    int m = amt % W;
    for (int j = 0; j < W; j++)
      if (left) r[(j + m) % W] = a[j];
      else      r[j] = a[(j + m) % W];
    return r;
  endfunction

  task automatic check(input string tag, input logic v, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (v !== 1'b1 || act !== exp) begin
      errors++;
      $display("FAIL %s: valid=%b result=%h expected valid=1 result=%h", tag, v, act, exp);
    end
  endtask

  task automatic runOp(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input int s, input int k, input int n1, input int n2,
                       input logic [W-1:0] exp, input string tag);
    @(negedge clk);
    opCode = op; srcA = a; srcB = b;
    startPos = LW'(s); fieldLen = LW'(k); cntA = LW'(n1); cntB = LW'(n2);
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(tag, outValid, result, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; inValid = 1'b0; opCode = '0; srcA = '0; srcB = '0;
    startPos = '0; fieldLen = '0; cntA = '0; cntB = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (outValid !== 1'b0 || result !== '0) begin
      errors++;
      $display("FAIL R10 reset: valid=%b result=%h expected valid=0 result=00", outValid, result);
    end
    rst = 1'b0;

    // R1 R2 R3: full extract sweep
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < (1 << LW); s++)
        for (int k = 0; k < (1 << LW); k++) begin
          string tag;
          if (k > W) tag = "R3 extract";
          else if (k == 0 || s + k > W) tag = "R2 extract";
          else tag = "R1 extract";
          runOp(2'b00, pattern(p), pattern(p + 1), s, k, 0, 0,
                refExtract(pattern(p), s, k), tag);
        end

    // R4 R5 R6: full concat sweep
    for (int p = 0; p < 4; p++)
      for (int n1 = 0; n1 < (1 << LW); n1++)
        for (int n2 = 0; n2 < (1 << LW); n2++) begin
          string tag;
          if (n1 > W || n2 > W) tag = "R6 concat";
          else if (n1 + n2 > W) tag = "R5 concat";
          else tag = "R4 concat";
          runOp(2'b01, pattern(p), ~pattern(p + 2), 0, 0, n1, n2,
                refConcat(pattern(p), ~pattern(p + 2), n1, n2), tag);
        end

    // R7 R8: rotates, amounts including multiples of W and upper srcB bits
    for (int p = 0; p < 5; p++)
      for (int amt = 0; amt < 4 * W + 3; amt++) begin
        runOp(2'b10, pattern(p), W'(amt), 0, 0, 0, 0, refRot(pattern(p), amt, 1'b1), "R7 rotl");
        runOp(2'b11, pattern(p), W'(amt), 0, 0, 0, 0, refRot(pattern(p), amt, 1'b0), "R8 rotr");
      end

    // R9: same operands and fields under each op code
    runOp(2'b00, 8'hB4, 8'h03, 2, 4, 3, 2, refExtract(8'hB4, 2, 4), "R9 op00");
    runOp(2'b01, 8'hB4, 8'h03, 2, 4, 3, 2, refConcat(8'hB4, 8'h03, 3, 2), "R9 op01");
    runOp(2'b10, 8'hB4, 8'h03, 2, 4, 3, 2, refRot(8'hB4, 3, 1'b1), "R9 op10");
    runOp(2'b11, 8'hB4, 8'h03, 2, 4, 3, 2, refRot(8'hB4, 3, 1'b0), "R9 op11");

    // R10: idle cycle keeps result, drops valid, even with inputs changing
    runOp(2'b10, 8'h96, 8'h01, 0, 0, 0, 0, 8'h2D, "R10 load");
    srcA = 8'h00; opCode = 2'b00;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || result !== 8'h2D) begin
      errors++;
      $display("FAIL R10 idle: valid=%b result=%h expected valid=0 result=2d", outValid, result);
    end

    // R10: reset during a pending request
    @(negedge clk);
    inValid = 1'b1; rst = 1'b1;
    @(negedge clk);
    inValid = 1'b0; rst = 1'b0;
    checks++;
    if (outValid !== 1'b0 || result !== '0) begin
      errors++;
      $display("FAIL R10 reset-pending: valid=%b result=%h expected valid=0 result=00",
               outValid, result);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule